// File: doc/BRIEF.md
# Timing Event Table Playback Engine

This block plays back preloaded timing event tables. It sends their events as a serial stream of event codes on one output. Each task slot owns a small table. An entry in the table holds a delay, counted in millisecond ticks, and an event code. A host interface uses a single write strobe and a command code to do the following:

- fill or clear the table
- set how many passes the task makes, where zero means it repeats without end
- arm the task on a trigger code
- end the task gracefully or at once

All task slots run independently. A fixed-priority arbiter merges their events into a single registered event port.

Timing inside the tables advances on a tick derived from the system clock. The tick fires once every `TICK_DIV` cycles, so with a 40 MHz clock and the default divider it marks whole milliseconds. A synchronizing event arrives on its own input. Every task that is armed with a matching trigger code starts on that same cycle. A combinational read port returns the state and the completed-pass count of any one task.

Top module: `ept_engine`

## Requirements
- R1: After reset every task reads state IDLE (0) and 0 passes, and `evt_vld_o` is low.
- R2: Command codes on `wr_cmd_i` are LOAD=0, UNLOAD=1, COUNT=2, ARM=3, STOP=4, ABORT=5. LOAD writes the delay and code at `wr_addr_i` and sets the table length to `wr_addr_i`+1. UNLOAD empties the table and returns the task to IDLE. An ARM on an empty table is ignored.
- R3: ARM moves a non-running task to ARMED with `wr_code_i` as its trigger code and clears its pass count. An armed task starts only when `sync_vld_i` is high with `sync_code_i` equal to that trigger code. Any other code leaves it ARMED with no events.
- R4: An entry with delay d > 0 is issued d ticks after the previous event of the same task, or after the start. With a tick every `TICK_DIV` cycles, that gap is between `TICK_DIV`*(d-1)+2 and `TICK_DIV`*d+1 cycles when no other task contends.
- R5: COUNT sets the number of passes from the low `PASS_W` bits of `wr_code_i`. With a count N > 0, the task issues its entries in table order N times, then reads DONE with N passes.
- R6: A count of 0 makes the task repeat its table until it is stopped or aborted.
- R7: STOP on a running task lets the current pass finish, then the task reads DONE. STOP on an armed task returns it to IDLE.
- R8: ABORT returns the task to IDLE at the next edge and no further event of that task is issued.
- R9: At most one event leaves per cycle. When several tasks are ready, the lowest task index goes first and the others hold their event until granted, so none is lost. `evt_task_o` carries the index of the task that issued the event.
- R10: An event is visible on the outputs one cycle after its request is granted. An entry of delay 0 therefore appears one cycle after the start or after the previous event.
- R11: `rd_state_o` reads the selected task's state, encoded as IDLE=0, ARMED=1, RUNNING=2, DONE=3. `rd_passes_o` reads its completed passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host command strobe |
| wr_cmd_i | input | 3 | Command code |
| wr_task_i | input | TID_W | Task addressed by the command |
| wr_addr_i | input | IDX_W | Table entry index for LOAD |
| wr_dly_i | input | DLY_W | Entry delay in ticks for LOAD |
| wr_code_i | input | CODE_W | Entry code, trigger code or pass count |
| sync_vld_i | input | 1 | Synchronizing event present |
| sync_code_i | input | CODE_W | Synchronizing event code |
| rd_task_i | input | TID_W | Task selected for status read |
| rd_state_o | output | 2 | State of the selected task |
| rd_passes_o | output | PASS_W | Completed passes of the selected task |
| evt_vld_o | output | 1 | Event output valid |
| evt_code_o | output | CODE_W | Event output code |
| evt_task_o | output | TID_W | Index of the task that issued the event |

## Verification
Host commands and sync events act at the clock edge that samples them. Status is therefore read just after that edge, through the combinational read port. The bench timestamps each event with the edge that registered it. The first event of a delay-0 entry must land exactly one edge after the start. Later events must fall inside the tick window of R4 measured from the previous edge. Because the tick phase floats, the bench compares each gap against that window and never against a single cycle. When several tasks contend, each event must come exactly one edge after the one before.

// File: rtl/ept_pkg.sv
package ept_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } task_st_e;

  typedef enum logic [2:0] {
    CMD_LOAD   = 3'd0,
    CMD_UNLOAD = 3'd1,
    CMD_COUNT  = 3'd2,
    CMD_ARM    = 3'd3,
    CMD_STOP   = 3'd4,
    CMD_ABORT  = 3'd5
  } cmd_e;
endpackage

// File: rtl/ept_tick_gen.sv
module ept_tick_gen #(
  parameter int unsigned TICK_DIV = 40000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + TW'(1);
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/ept_task.sv
module ept_task
  import ept_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DLY_W  = 16,
  parameter int unsigned CODE_W = 32,
  parameter int unsigned PASS_W = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cmd_en_i,
  input  cmd_e              cmd_i,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              sync_vld_i,
  input  logic [CODE_W-1:0] sync_code_i,
  input  logic              gnt_i,
  output logic              req_o,
  output logic [CODE_W-1:0] req_code_o,
  output logic [1:0]        state_o,
  output logic [PASS_W-1:0] passes_o
);
  logic [DLY_W-1:0]  dly_q  [DEPTH];
  logic [CODE_W-1:0] code_q [DEPTH];

  task_st_e          st_q;
  logic [LEN_W-1:0]  len_q;
  logic [PASS_W-1:0] count_q, passes_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DLY_W-1:0]  cnt_q;
  logic              stop_q;
  logic [CODE_W-1:0] trig_q;

  logic kill, last_ent, end_run;

  assign kill     = cmd_en_i && (cmd_i == CMD_ABORT || cmd_i == CMD_UNLOAD);
  assign last_ent = (LEN_W'(idx_q) + LEN_W'(1)) >= len_q;
  assign end_run  = stop_q || (count_q != '0 && (passes_q + PASS_W'(1)) == count_q);

  // table storage, no reset
  always_ff @(posedge clk_i) begin
    if (cmd_en_i && cmd_i == CMD_LOAD) begin
      dly_q[addr_i]  <= dly_i;
      code_q[addr_i] <= code_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      len_q    <= '0;
      count_q  <= PASS_W'(1);
      passes_q <= '0;
      idx_q    <= '0;
      cnt_q    <= '0;
      stop_q   <= 1'b0;
      trig_q   <= '0;
    end else begin
      case (st_q)
        ST_ARMED: begin
          if (sync_vld_i && sync_code_i == trig_q) begin
            st_q   <= ST_RUN;
            idx_q  <= '0;
            cnt_q  <= dly_q[0];
            stop_q <= 1'b0;
          end
        end
        ST_RUN: begin
          if (gnt_i) begin
            if (last_ent) begin
              passes_q <= passes_q + PASS_W'(1);
              idx_q    <= '0;
              cnt_q    <= dly_q[0];
              if (end_run) st_q <= ST_DONE;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
              cnt_q <= dly_q[idx_q + IDX_W'(1)];
            end
          end else if (tick_i && cnt_q != '0) begin
            cnt_q <= cnt_q - DLY_W'(1);
          end
        end
        default: ;
      endcase

      // host commands override progression
      if (cmd_en_i) begin
        case (cmd_i)
          CMD_LOAD:   len_q <= LEN_W'(addr_i) + LEN_W'(1);
          CMD_UNLOAD: begin
            len_q  <= '0;
            st_q   <= ST_IDLE;
            stop_q <= 1'b0;
          end
          CMD_COUNT:  count_q <= code_i[PASS_W-1:0];
          CMD_ARM: begin
            if (len_q != '0 && st_q != ST_RUN) begin
              st_q     <= ST_ARMED;
              trig_q   <= code_i;
              passes_q <= '0;
            end
          end
          CMD_STOP: begin
            if (st_q == ST_RUN)        stop_q <= 1'b1;
            else if (st_q == ST_ARMED) st_q   <= ST_IDLE;
          end
          CMD_ABORT: begin
            st_q   <= ST_IDLE;
            stop_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign req_o      = (st_q == ST_RUN) && (cnt_q == '0) && !kill;
  assign req_code_o = code_q[idx_q];
  assign state_o    = st_q;
  assign passes_o   = passes_q;
endmodule

// File: rtl/ept_arb.sv
module ept_arb #(
  parameter int unsigned N_TASKS = 16,
  parameter int unsigned CODE_W  = 32,
  localparam int unsigned TID_W  = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_TASKS-1:0]             req_i,
  input  logic [N_TASKS-1:0][CODE_W-1:0] code_i,
  output logic [N_TASKS-1:0]             gnt_o,
  output logic                           evt_vld_o,
  output logic [CODE_W-1:0]              evt_code_o,
  output logic [TID_W-1:0]               evt_task_o
);
  logic [TID_W-1:0] sel;
  logic             hit;

  always_comb begin
    gnt_o = '0;
    sel   = '0;
    hit   = 1'b0;
    for (int i = 0; i < int'(N_TASKS); i++) begin
      if (req_i[i] && !hit) begin
        gnt_o[i] = 1'b1;
        sel      = TID_W'(i);
        hit      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_vld_o  <= 1'b0;
      evt_code_o <= '0;
      evt_task_o <= '0;
    end else begin
      evt_vld_o <= hit;
      if (hit) begin
        evt_code_o <= code_i[sel];
        evt_task_o <= sel;
      end
    end
  end
endmodule

// File: rtl/ept_engine.sv
module ept_engine
  import ept_pkg::*;
#(
  parameter int unsigned N_TASKS  = 16,
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned DLY_W    = 16,
  parameter int unsigned CODE_W   = 32,
  parameter int unsigned PASS_W   = 8,
  parameter int unsigned TICK_DIV = 40000,
  localparam int unsigned TID_W   = (N_TASKS > 1) ? $clog2(N_TASKS) : 1,
  localparam int unsigned IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_cmd_i,
  input  logic [TID_W-1:0]  wr_task_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [DLY_W-1:0]  wr_dly_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic              sync_vld_i,
  input  logic [CODE_W-1:0] sync_code_i,
  input  logic [TID_W-1:0]  rd_task_i,
  output logic [1:0]        rd_state_o,
  output logic [PASS_W-1:0] rd_passes_o,
  output logic              evt_vld_o,
  output logic [CODE_W-1:0] evt_code_o,
  output logic [TID_W-1:0]  evt_task_o
);
  logic                           tick;
  logic [N_TASKS-1:0]             req_w, gnt_w;
  logic [N_TASKS-1:0][CODE_W-1:0] code_w;
  logic [N_TASKS-1:0][1:0]        st_w;
  logic [N_TASKS-1:0][PASS_W-1:0] pass_w;
  cmd_e                           cmd;

  assign cmd = cmd_e'(wr_cmd_i);

  ept_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  for (genvar g = 0; g < int'(N_TASKS); g++) begin : g_task
    logic sel_en;
    assign sel_en = wr_en_i && (wr_task_i == TID_W'(g));

    ept_task #(
      .DEPTH (DEPTH),
      .DLY_W (DLY_W),
      .CODE_W(CODE_W),
      .PASS_W(PASS_W)
    ) u_task (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick),
      .cmd_en_i    (sel_en),
      .cmd_i       (cmd),
      .addr_i      (wr_addr_i),
      .dly_i       (wr_dly_i),
      .code_i      (wr_code_i),
      .sync_vld_i  (sync_vld_i),
      .sync_code_i (sync_code_i),
      .gnt_i       (gnt_w[g]),
      .req_o       (req_w[g]),
      .req_code_o  (code_w[g]),
      .state_o     (st_w[g]),
      .passes_o    (pass_w[g])
    );
  end

  ept_arb #(.N_TASKS(N_TASKS), .CODE_W(CODE_W)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_w),
    .code_i     (code_w),
    .gnt_o      (gnt_w),
    .evt_vld_o  (evt_vld_o),
    .evt_code_o (evt_code_o),
    .evt_task_o (evt_task_o)
  );

  assign rd_state_o  = st_w[rd_task_i];
  assign rd_passes_o = pass_w[rd_task_i];
endmodule

// File: rtl/ept_checks.sv
module ept_checks #(
  parameter int unsigned N_TASKS = 16,
  localparam int unsigned TID_W  = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     wr_en_i,
  input logic [2:0]               wr_cmd_i,
  input logic [TID_W-1:0]         wr_task_i,
  input logic [N_TASKS-1:0]       req,
  input logic [N_TASKS-1:0]       gnt,
  input logic [N_TASKS-1:0][1:0]  st,
  input logic                     evt_vld_o
);
  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt)); // R9
  AST_REQ_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req) |-> (|gnt)); // R9
  AST_EVT_AFTER_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt) |=> evt_vld_o); // R10
  AST_EVT_NEEDS_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_vld_o |-> $past(|gnt)); // R10

  for (genvar i = 0; i < int'(N_TASKS); i++) begin : g_chk
    AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req[i] && !gnt[i] && !wr_en_i) |=> req[i]); // R9
    AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_cmd_i == 3'd5 && wr_task_i == TID_W'(i)) |=> (st[i] == 2'd0)); // R8
  end
endmodule

bind ept_engine ept_checks #(.N_TASKS(N_TASKS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_cmd_i  (wr_cmd_i),
  .wr_task_i (wr_task_i),
  .req       (req_w),
  .gnt       (gnt_w),
  .st        (st_w),
  .evt_vld_o (evt_vld_o)
);

// File: tb/tb_ept_engine.sv
`timescale 1ns/1ps
module tb_ept_engine;
  localparam int NT = 4, DEP = 4, DW = 4, CW = 32, PW = 8, TDIV = 4, TW = 2, IW = 2;
  localparam logic [2:0] C_LOAD = 3'd0, C_UNLOAD = 3'd1, C_COUNT = 3'd2,
                         C_ARM = 3'd3, C_STOP = 3'd4, C_ABORT = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          wr_en = 1'b0;
  logic [2:0]    wr_cmd = '0;
  logic [TW-1:0] wr_task = '0, rd_task = '0;
  logic [IW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_dly = '0;
  logic [CW-1:0] wr_code = '0, sync_code = '0;
  logic          sync_vld = 1'b0;
  logic [1:0]    rd_state;
  logic [PW-1:0] rd_passes;
  logic          evt_vld;
  logic [CW-1:0] evt_code;
  logic [TW-1:0] evt_task;

  ept_engine #(.N_TASKS(NT), .DEPTH(DEP), .DLY_W(DW), .CODE_W(CW), .PASS_W(PW),
               .TICK_DIV(TDIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_cmd_i(wr_cmd),
    .wr_task_i(wr_task), .wr_addr_i(wr_addr), .wr_dly_i(wr_dly), .wr_code_i(wr_code),
    .sync_vld_i(sync_vld), .sync_code_i(sync_code), .rd_task_i(rd_task),
    .rd_state_o(rd_state), .rd_passes_o(rd_passes), .evt_vld_o(evt_vld),
    .evt_code_o(evt_code), .evt_task_o(evt_task));

  int n_chk = 0, n_fail = 0, cyc = 0, n_ev = 0;
  logic [CW-1:0] ev_code [0:511];
  int            ev_task [0:511];
  int            ev_cyc  [0:511];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (rst_n && evt_vld && n_ev < 512) begin
      ev_code[n_ev] = evt_code;
      ev_task[n_ev] = int'(evt_task);
      ev_cyc[n_ev]  = cyc;
      n_ev++;
    end
  end

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", r, a, e);
    end
  endtask

  task automatic chk_rng(input string r, input int a, input int lo, input int hi);
    n_chk++;
    if (a < lo || a > hi) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d..%0d", r, a, lo, hi);
    end
  endtask

  task automatic host(input logic [2:0] c, input int t, input int ad, input int d,
                      input logic [31:0] code);
    @(negedge clk);
    wr_en = 1'b1; wr_cmd = c; wr_task = TW'(t); wr_addr = IW'(ad);
    wr_dly = DW'(d); wr_code = code;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fire_sync(input logic [31:0] code, output int edge_no);
    @(negedge clk);
    sync_vld = 1'b1; sync_code = code; edge_no = cyc + 1;
    @(negedge clk);
    sync_vld = 1'b0;
  endtask

  task automatic rd(input int t, output logic [1:0] s, output logic [PW-1:0] p);
    rd_task = TW'(t);
    #0.5;
    s = rd_state; p = rd_passes;
  endtask

  task automatic wait_st(input int t, input logic [1:0] want, input int maxc);
    logic [1:0] s; logic [PW-1:0] p;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      rd(t, s, p);
      if (s == want) return;
    end
  endtask

  function automatic logic [31:0] mk(input int l, input int c, input int t, input int e);
    return 32'hC000_0000 | 32'(l << 12) | 32'(c << 8) | 32'(t << 4) | 32'(e);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=completion");
    summary();
  end

  initial begin
    logic [1:0] s; logic [PW-1:0] p;
    int t, base, se, prev, gap, d, e, k0;
    logic [31:0] trig;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NT; i++) begin
      rd(i, s, p);
      chk("R1 state", 32'(s), 0);
      chk("R1 passes", 32'(p), 0);
    end
    chk("R1 no event", 32'(evt_vld), 0);

    // sweep table length and run count
    for (int L = 1; L <= 4; L++) begin
      for (int C = 1; C <= 3; C++) begin
        t = (L + C) % NT;
        trig = 32'h100 + 32'(L * 8 + C);
        for (int ei = 0; ei < L; ei++) host(C_LOAD, t, ei, (L + ei + C) % 3, mk(L, C, t, ei));
        host(C_COUNT, t, 0, 0, 32'(C));
        host(C_ARM, t, 0, 0, trig);
        rd(t, s, p);
        chk("R3 armed", 32'(s), 1);
        chk("R11 passes cleared by arm", 32'(p), 0);
        base = n_ev;
        fire_sync(trig, se);
        wait_st(t, 2'd3, 400);
        repeat (2) @(negedge clk);
        chk("R5 event count", 32'(n_ev - base), 32'(L * C));
        prev = se;
        for (int kk = 0; kk < L * C && base + kk < n_ev; kk++) begin
          e = kk % L;
          d = (L + e + C) % 3;
          chk("R5 code order", ev_code[base + kk], mk(L, C, t, e));
          chk("R9 task id", 32'(ev_task[base + kk]), 32'(t));
          gap = ev_cyc[base + kk] - prev;
          if (d == 0) chk("R10 zero delay latency", 32'(gap), 1);
          else chk_rng("R4 delay gap", gap, TDIV * (d - 1) + 2, TDIV * d + 1);
          prev = ev_cyc[base + kk];
        end
        rd(t, s, p);
        chk("R5 done state", 32'(s), 3);
        chk("R11 passes", 32'(p), 32'(C));
      end
    end

    // forever mode then graceful stop
    host(C_LOAD, 1, 0, 0, 32'hF0);
    host(C_LOAD, 1, 1, 1, 32'hF1);
    host(C_COUNT, 1, 0, 0, 32'd0);
    host(C_ARM, 1, 0, 0, 32'h200);
    base = n_ev;
    fire_sync(32'h200, se);
    repeat (60) @(negedge clk);
    rd(1, s, p);
    chk("R6 still running", 32'(s), 2);
    host(C_STOP, 1, 0, 0, 0);
    wait_st(1, 2'd3, 200);
    repeat (2) @(negedge clk);
    rd(1, s, p);
    chk("R7 done after stop", 32'(s), 3);
    chk_rng("R6 many passes", n_ev - base, 8, 400);
    chk("R7 whole passes", 32'((n_ev - base) % 2), 0);
    chk("R7 last entry", ev_code[n_ev - 1], 32'hF1);
    chk("R11 passes after stop", 32'(p), 32'((n_ev - base) / 2));

    // abort mid-pass
    for (int ei = 0; ei < 3; ei++) host(C_LOAD, 2, ei, 3, 32'hA0 + 32'(ei));
    host(C_COUNT, 2, 0, 0, 32'd0);
    host(C_ARM, 2, 0, 0, 32'h300);
    base = n_ev;
    fire_sync(32'h300, se);
    for (int i = 0; i < 200 && n_ev - base < 2; i++) @(negedge clk);
    host(C_ABORT, 2, 0, 0, 0);
    rd(2, s, p);
    chk("R8 idle after abort", 32'(s), 0);
    k0 = n_ev;
    repeat (60) @(negedge clk);
    chk("R8 no further events", 32'(n_ev - k0), 0);

    // trigger code matching
    host(C_LOAD, 3, 0, 1, 32'hE3);
    host(C_COUNT, 3, 0, 0, 32'd1);
    host(C_ARM, 3, 0, 0, 32'h400);
    base = n_ev;
    fire_sync(32'h401, se);
    repeat (30) @(negedge clk);
    rd(3, s, p);
    chk("R3 wrong code keeps armed", 32'(s), 1);
    chk("R3 wrong code no event", 32'(n_ev - base), 0);
    fire_sync(32'h400, se);
    wait_st(3, 2'd3, 100);
    repeat (2) @(negedge clk);
    chk("R3 matched start count", 32'(n_ev - base), 1);
    chk("R3 matched start code", ev_code[n_ev - 1], 32'hE3);

    // stop while armed
    host(C_ARM, 3, 0, 0, 32'h400);
    rd(3, s, p);
    chk("R11 passes reset by arm", 32'(p), 0);
    host(C_STOP, 3, 0, 0, 0);
    rd(3, s, p);
    chk("R7 stop while armed", 32'(s), 0);

    // unload then arm is ignored
    host(C_UNLOAD, 0, 0, 0, 0);
    rd(0, s, p);
    chk("R2 unload idle", 32'(s), 0);
    host(C_ARM, 0, 0, 0, 32'h450);
    rd(0, s, p);
    chk("R2 arm on empty ignored", 32'(s), 0);
    base = n_ev;
    fire_sync(32'h450, se);
    repeat (20) @(negedge clk);
    chk("R2 empty table silent", 32'(n_ev - base), 0);

    // arbitration between two ready tasks
    for (int ei = 0; ei < 3; ei++) begin
      host(C_LOAD, 0, ei, 0, 32'hA00 + 32'(ei));
      host(C_LOAD, 1, ei, 0, 32'hB00 + 32'(ei));
    end
    host(C_COUNT, 0, 0, 0, 32'd1);
    host(C_COUNT, 1, 0, 0, 32'd1);
    host(C_ARM, 0, 0, 0, 32'h500);
    host(C_ARM, 1, 0, 0, 32'h500);
    base = n_ev;
    fire_sync(32'h500, se);
    repeat (20) @(negedge clk);
    chk("R9 no event lost", 32'(n_ev - base), 6);
    prev = se;
    for (int kk = 0; kk < 6 && base + kk < n_ev; kk++) begin
      chk("R9 priority order", ev_code[base + kk],
          (kk < 3) ? 32'hA00 + 32'(kk) : 32'hB00 + 32'(kk - 3));
      chk("R9 task id", 32'(ev_task[base + kk]), (kk < 3) ? 0 : 1);
      chk("R10 one per cycle", 32'(ev_cyc[base + kk] - prev), 1);
      prev = ev_cyc[base + kk];
    end

    summary();
  end
endmodule